// File: doc/BRIEF.md
# Serial Control Register Port with Fast-Gain Combiner

This block takes a three-wire serial write stream (serial clock, serial data, strobe) and keeps the control settings of a receive chain. Data bits enter a 32-bit shift register least significant bit first, one bit per rising serial clock edge. A rising strobe edge then commits the whole word to one of two control registers: a device setup register or a calibration setup register. The two lowest bits of the word choose the register.

Every control field is driven out as its own port:

- power-down bits
- baseband gain code and filter cutoff code
- detector bandwidth select
- calibration mode, start and reset bits
- I and Q correction DAC codes and resolution codes
- calibration clock divider select, oscillator select and oscillator trim

The block also adds the serial gain code to a 3-bit parallel fast-gain input, giving one effective gain word. That word is limited to 24. When the calibration engine reports completion, the block clears the calibration start bit.

The serial clock, data and strobe are asynchronous to the system clock. Each passes through a two-flop synchronizer. Edge detection, shifting and commits all happen in the system clock domain.

Top module: `serial_ctl_regs`

## Requirements
- R1: Each rising serial clock edge shifts one data bit into the frame. The first bit of a 32-bit frame ends up in bit 0, so bit i of the frame is the i-th bit sent, counting from 0.
- R2: Shifting alone never changes any control output. A register changes only after a rising strobe edge, and the output is updated within 8 system clock cycles of that edge.
- R3: Frame bits 1:0 hold the address. Address 0 writes the device setup register; address 1 writes the calibration setup register.
- R4: Device setup register layout (bit positions):
  - mixer power-down: bit 2
  - LO buffer power-down: bit 3
  - test buffer power-down: bit 4
  - filter power-down: bit 5
  - output buffer power-down: bit 6
  - digital calibration power-down: bit 8
  - analog calibration power-down: bit 9
  - gain code: bits 14:10
  - cutoff code: bits 21:15
  - detector bandwidth: bits 25:24
  - calibration logic reset: bit 29

  After reset: test buffer and both calibration power-downs are 1, gain code is 15, cutoff code is 85, and every other output field is 0.
- R5: Calibration setup register layout (bit positions):
  - auto mode: bit 2
  - start: bit 3
  - I DAC code: bits 11:4
  - Q DAC code: bits 19:12
  - I resolution: bits 21:20
  - Q resolution: bits 23:22
  - binary search: bit 24
  - divider select: bits 27:25
  - oscillator select: bit 28
  - oscillator trim: bits 31:29

  After reset: auto mode is 1, start is 0, both DAC codes are 128, both resolution codes are 3, binary search is 1, divider select is 0, oscillator select is 1, and trim is 3.
- R6: A committed frame with address 2 or 3 leaves both registers unchanged.
- R7: The effective gain equals gain code plus fast-gain input whenever that sum is 24 or less. It follows the inputs combinationally.
- R8: A sum above 24 gives an effective gain of 24. It also sets a gain-invalid flag one cycle later, and only reset clears that flag.
- R9: A one-cycle completion pulse clears the calibration start bit on the next clock edge and leaves the other calibration fields unchanged. If a commit to the calibration register happens on the same edge, the committed word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, least significant bit first |
| ser_strobe | input | 1 | Commit strobe, rising edge active, asynchronous |
| fast_gain | input | 3 | Parallel gain offset, 0 to 7 |
| cal_done | input | 1 | Calibration complete pulse |
| pd_mix | output | 1 | Mixer power-down |
| pd_lo | output | 1 | LO buffer power-down |
| pd_testbuf | output | 1 | Test buffer power-down |
| pd_filt | output | 1 | Filter power-down |
| pd_outbuf | output | 1 | Output buffer power-down |
| pd_cal_dig | output | 1 | Digital calibration power-down |
| pd_cal_ana | output | 1 | Analog calibration power-down |
| gain_code | output | 5 | Serial gain code |
| cutoff_code | output | 7 | Filter cutoff code |
| det_bw | output | 2 | Detector bandwidth select |
| cal_logic_rst | output | 1 | Calibration logic reset |
| cal_auto | output | 1 | Automatic calibration mode |
| cal_start | output | 1 | Calibration start |
| dac_i | output | 8 | I correction DAC code |
| dac_q | output | 8 | Q correction DAC code |
| res_i | output | 2 | I correction resolution |
| res_q | output | 2 | Q correction resolution |
| bin_search | output | 1 | Binary search enable |
| cal_div_sel | output | 3 | Calibration clock divider select |
| osc_sel | output | 1 | Internal oscillator select |
| osc_trim | output | 3 | Oscillator trim |
| eff_gain | output | 5 | Effective gain, 0 to 24 |
| gain_invalid | output | 1 | Sticky gain-overflow flag |

## Verification
The assertions assume three things about the inputs:

- Serial data is steady across each serial clock rising edge.
- Every serial clock and strobe level lasts at least a few system clock cycles, so no edge is lost in the synchronizers.
- The completion pulse lasts one cycle.

The stimulus keeps within these limits. It holds each data bit for several cycles before and after the serial clock rises, keeps the serial clock high for four cycles, and raises the strobe only after the serial clock has gone low. It changes every input on the falling system clock edge.

// File: rtl/serial_ctl_pkg.sv
// Package: frame geometry, register reset words and field positions shared
// by the serial control register port. Assumes a 32-bit frame.
package serial_ctl_pkg;
    localparam int FRAME_W   = 32;
    localparam int ADDR_W    = 2;
    localparam int REG_COUNT = 2;
    localparam int START_BIT = 3;

    // Reset word of register r (0 = device setup, 1 = calibration setup)
    function automatic logic [FRAME_W-1:0] reset_word(input int r);
        logic [FRAME_W-1:0] w;
        w = '0;
        if (r == 0) begin
            w[4]     = 1'b1;
            w[8]     = 1'b1;
            w[9]     = 1'b1;
            w[14:10] = 5'd15;
            w[21:15] = 7'd85;
            w[22]    = 1'b1;
        end else begin
            w[0]     = 1'b1;
            w[2]     = 1'b1;
            w[11:4]  = 8'd128;
            w[19:12] = 8'd128;
            w[23:20] = 4'hF;
            w[24]    = 1'b1;
            w[28]    = 1'b1;
            w[31:29] = 3'b011;
        end
        return w;
    endfunction
endpackage

// File: rtl/bit_sync.sv
// Multi-bit level synchronizer: each bit passes independently through
// STAGES flops. Assumes every input level lasts longer than STAGES cycles.
module bit_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    // Shift each input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= async_in;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
// Serial frame shifter: finds rising serial clock edges on the synchronized
// clock and shifts the synchronized data bit in at the top, so the first bit
// sent ends at bit 0. Keeps the last FRAME_W bits; no bit counter.
module frame_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_sync,
    input  logic               sdata_sync,
    output logic [FRAME_W-1:0] frame
);
    logic sclk_prev;
    logic sclk_rise;

    assign sclk_rise = sclk_sync & ~sclk_prev;

    // Remember previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_sync;
    end

    // Shift one bit per serial clock rise, least significant bit first
    always_ff @(posedge clk) begin
        if (!rst_n)         frame <= '0;
        else if (sclk_rise) frame <= {sdata_sync, frame[FRAME_W-1:1]};
    end

    AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(frame)); // R1
endmodule

// File: rtl/gain_combiner.sv
// Effective gain: serial gain code plus parallel fast-gain offset, limited to
// GAIN_MAX, with a sticky flag set one cycle after any overflowing sum.
module gain_combiner #(
    parameter int GAIN_W   = 5,
    parameter int FAST_W   = 3,
    parameter int GAIN_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] gain_code,
    input  logic [FAST_W-1:0] fast_gain,
    output logic [GAIN_W-1:0] eff_gain,
    output logic              gain_invalid
);
    localparam int SUM_W = GAIN_W + 1;
    logic [SUM_W-1:0] sum;
    logic             over;

    // Add and limit the two gain sources
    always_comb begin
        sum      = SUM_W'(gain_code) + SUM_W'(fast_gain);
        over     = sum > SUM_W'(GAIN_MAX);
        eff_gain = over ? GAIN_W'(GAIN_MAX) : sum[GAIN_W-1:0];
    end

    // Sticky overflow flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)    gain_invalid <= 1'b0;
        else if (over) gain_invalid <= 1'b1;
    end

    AST_GAIN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        eff_gain <= GAIN_W'(GAIN_MAX)); // R8
    AST_OVER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> gain_invalid); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        gain_invalid |=> gain_invalid); // R8
endmodule

// File: rtl/serial_ctl_regs.sv
// Top: three-wire serial control port. Synchronizes serial clock, data and
// strobe, shifts frames, commits on strobe rise to the addressed register,
// decodes fields and forms the effective gain. Assumes input levels last
// several system clock cycles and cal_done is a single-cycle pulse.
module serial_ctl_regs
    import serial_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAIN_W      = 5,
    parameter int FAST_W      = 3,
    parameter int GAIN_MAX    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_strobe,
    input  logic [FAST_W-1:0] fast_gain,
    input  logic              cal_done,
    output logic              pd_mix,
    output logic              pd_lo,
    output logic              pd_testbuf,
    output logic              pd_filt,
    output logic              pd_outbuf,
    output logic              pd_cal_dig,
    output logic              pd_cal_ana,
    output logic [GAIN_W-1:0] gain_code,
    output logic [6:0]        cutoff_code,
    output logic [1:0]        det_bw,
    output logic              cal_logic_rst,
    output logic              cal_auto,
    output logic              cal_start,
    output logic [7:0]        dac_i,
    output logic [7:0]        dac_q,
    output logic [1:0]        res_i,
    output logic [1:0]        res_q,
    output logic              bin_search,
    output logic [2:0]        cal_div_sel,
    output logic              osc_sel,
    output logic [2:0]        osc_trim,
    output logic [GAIN_W-1:0] eff_gain,
    output logic              gain_invalid
);
    logic [2:0]         sync_bits;
    logic               strobe_prev;
    logic               commit;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] regs [REG_COUNT];
    logic [FRAME_W-1:0] dev_word;
    logic [FRAME_W-1:0] cal_word;

    bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_strobe, ser_data, ser_clk}),
        .sync_out (sync_bits)
    );

    frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_sync  (sync_bits[0]),
        .sdata_sync (sync_bits[1]),
        .frame      (frame)
    );

    // Remember previous strobe level for rising edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev <= 1'b0;
        else        strobe_prev <= sync_bits[2];
    end
    assign commit = sync_bits[2] & ~strobe_prev;

    // One register per address; the calibration register also self-clears its start bit
    for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[r] <= reset_word(r);
            else if (commit && frame[ADDR_W-1:0] == ADDR_W'(r))
                regs[r] <= frame;
            else if (r == 1 && cal_done)
                regs[r][START_BIT] <= 1'b0;
        end
    end

    assign dev_word = regs[0];
    assign cal_word = regs[1];

    // Field decode of the device setup register
    assign pd_mix        = dev_word[2];
    assign pd_lo         = dev_word[3];
    assign pd_testbuf    = dev_word[4];
    assign pd_filt       = dev_word[5];
    assign pd_outbuf     = dev_word[6];
    assign pd_cal_dig    = dev_word[8];
    assign pd_cal_ana    = dev_word[9];
    assign gain_code     = dev_word[14:10];
    assign cutoff_code   = dev_word[21:15];
    assign det_bw        = dev_word[25:24];
    assign cal_logic_rst = dev_word[29];

    // Field decode of the calibration setup register
    assign cal_auto    = cal_word[2];
    assign cal_start   = cal_word[START_BIT];
    assign dac_i       = cal_word[11:4];
    assign dac_q       = cal_word[19:12];
    assign res_i       = cal_word[21:20];
    assign res_q       = cal_word[23:22];
    assign bin_search  = cal_word[24];
    assign cal_div_sel = cal_word[27:25];
    assign osc_sel     = cal_word[28];
    assign osc_trim    = cal_word[31:29];

    logic unused_bits;
    assign unused_bits = ^{dev_word[1:0], dev_word[7], dev_word[23:22],
                           dev_word[28:26], dev_word[31:30], cal_word[1:0]};

    gain_combiner #(.GAIN_W(GAIN_W), .FAST_W(FAST_W), .GAIN_MAX(GAIN_MAX)) u_gain (
        .clk          (clk),
        .rst_n        (rst_n),
        .gain_code    (gain_code),
        .fast_gain    (fast_gain),
        .eff_gain     (eff_gain),
        .gain_invalid (gain_invalid)
    );

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !cal_done) |=> ($stable(dev_word) && $stable(cal_word))); // R2
    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame[ADDR_W-1] && !cal_done) |=> ($stable(dev_word) && $stable(cal_word))); // R6
    AST_DEV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame[ADDR_W-1:0] == '0) |=> (dev_word == $past(frame))); // R3
    AST_DONE_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !commit) |=> !cal_start); // R9
endmodule

// File: tb/tb_serial_ctl_regs.sv
module tb_serial_ctl_regs;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ser_clk = 0, ser_data = 0, ser_strobe = 0, cal_done = 0;
    logic [2:0] fast_gain = 0;
    logic pd_mix, pd_lo, pd_testbuf, pd_filt, pd_outbuf, pd_cal_dig, pd_cal_ana;
    logic [4:0] gain_code, eff_gain;
    logic [6:0] cutoff_code;
    logic [1:0] det_bw, res_i, res_q;
    logic cal_logic_rst, cal_auto, cal_start, bin_search, osc_sel, gain_invalid;
    logic [7:0] dac_i, dac_q;
    logic [2:0] cal_div_sel, osc_trim;

    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    serial_ctl_regs dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(logic [31:0] w);
        for (int i = 0; i < 32; i++) begin
            ser_data = w[i];
            wait_cyc(4);
            ser_clk = 1;
            wait_cyc(4);
            ser_clk = 0;
            wait_cyc(2);
        end
    endtask

    task automatic pulse_strobe();
        ser_strobe = 1;
        wait_cyc(4);
        ser_strobe = 0;
        wait_cyc(8);
    endtask

    task automatic write_frame(logic [31:0] w);
        send_bits(w);
        pulse_strobe();
    endtask

    task automatic check_dev(string tag, logic [31:0] w);
        chk({tag, " pd_mix"}, pd_mix, w[2]);
        chk({tag, " pd_lo"}, pd_lo, w[3]);
        chk({tag, " pd_testbuf"}, pd_testbuf, w[4]);
        chk({tag, " pd_filt"}, pd_filt, w[5]);
        chk({tag, " pd_outbuf"}, pd_outbuf, w[6]);
        chk({tag, " pd_cal_dig"}, pd_cal_dig, w[8]);
        chk({tag, " pd_cal_ana"}, pd_cal_ana, w[9]);
        chk({tag, " gain_code"}, gain_code, w[14:10]);
        chk({tag, " cutoff"}, cutoff_code, w[21:15]);
        chk({tag, " det_bw"}, det_bw, w[25:24]);
        chk({tag, " cal_logic_rst"}, cal_logic_rst, w[29]);
    endtask

    task automatic check_cal(string tag, logic [31:0] w);
        chk({tag, " cal_auto"}, cal_auto, w[2]);
        chk({tag, " cal_start"}, cal_start, w[3]);
        chk({tag, " dac_i"}, dac_i, w[11:4]);
        chk({tag, " dac_q"}, dac_q, w[19:12]);
        chk({tag, " res_i"}, res_i, w[21:20]);
        chk({tag, " res_q"}, res_q, w[23:22]);
        chk({tag, " bin_search"}, bin_search, w[24]);
        chk({tag, " div_sel"}, cal_div_sel, w[27:25]);
        chk({tag, " osc_sel"}, osc_sel, w[28]);
        chk({tag, " osc_trim"}, osc_trim, w[31:29]);
    endtask

    logic [31:0] dev_exp, cal_exp;

    // R4 R5: reset values
    task automatic t_reset();
        dev_exp = 32'h0;
        dev_exp[4] = 1; dev_exp[8] = 1; dev_exp[9] = 1;
        dev_exp[14:10] = 15; dev_exp[21:15] = 85;
        cal_exp = 32'h0;
        cal_exp[2] = 1; cal_exp[11:4] = 128; cal_exp[19:12] = 128;
        cal_exp[23:20] = 4'hF; cal_exp[24] = 1; cal_exp[28] = 1; cal_exp[31:29] = 3'b011;
        check_dev("R4 reset", dev_exp);
        check_cal("R5 reset", cal_exp);
        chk("R8 reset flag", gain_invalid, 0);
        chk("R7 reset eff_gain", eff_gain, 15);
    endtask

    // R1 R3 R4: device register write, LSB-first placement
    task automatic t_dev_write();
        dev_exp = 32'hA5D3_9B6C;
        dev_exp[1:0] = 2'd0;
        dev_exp[14:10] = 5'd9;
        write_frame(dev_exp);
        check_dev("R1 R3 R4 dev write", dev_exp);
        check_cal("R3 cal untouched", cal_exp);
    endtask

    // R2: shifting without strobe leaves outputs unchanged, strobe then commits
    task automatic t_no_strobe();
        logic [31:0] w;
        w = 32'h3C00_7E54;
        w[1:0] = 2'd1;
        w[3] = 0;
        send_bits(w);
        wait_cyc(10);
        check_cal("R2 no strobe", cal_exp);
        pulse_strobe();
        cal_exp = w;
        check_cal("R2 R5 cal write", cal_exp);
        check_dev("R3 dev untouched", dev_exp);
    endtask

    // R6: addresses 2 and 3 discarded
    task automatic t_bad_addr();
        write_frame(32'hFFFF_FFFE);
        check_dev("R6 addr2 dev", dev_exp);
        check_cal("R6 addr2 cal", cal_exp);
        write_frame(32'h0000_0003);
        check_dev("R6 addr3 dev", dev_exp);
        check_cal("R6 addr3 cal", cal_exp);
    endtask

    // R7 R8: gain sum, saturation, sticky flag
    task automatic t_gain();
        dev_exp[14:10] = 5'd10;
        write_frame(dev_exp);
        fast_gain = 3'd5;
        wait_cyc(1);
        chk("R7 10+5", eff_gain, 15);
        fast_gain = 3'd7;
        wait_cyc(2);
        chk("R7 10+7", eff_gain, 17);
        chk("R8 no flag at 17", gain_invalid, 0);
        dev_exp[14:10] = 5'd17;
        write_frame(dev_exp);
        chk("R7 17+7 boundary", eff_gain, 24);
        chk("R8 no flag at 24", gain_invalid, 0);
        dev_exp[14:10] = 5'd20;
        write_frame(dev_exp);
        chk("R8 20+7 saturates", eff_gain, 24);
        chk("R8 flag set", gain_invalid, 1);
        fast_gain = 3'd1;
        wait_cyc(3);
        chk("R7 20+1", eff_gain, 21);
        chk("R8 flag sticky", gain_invalid, 1);
        fast_gain = 3'd0;
    endtask

    // R9: completion pulse clears start; same-edge commit wins
    task automatic t_cal_done();
        cal_exp[3] = 1;
        cal_exp[1:0] = 2'd1;
        write_frame(cal_exp);
        chk("R9 start set", cal_start, 1);
        cal_done = 1;
        wait_cyc(1);
        cal_done = 0;
        wait_cyc(1);
        cal_exp[3] = 0;
        check_cal("R9 done clears start", cal_exp);
        // Commit edge lands 3 cycles after strobe rises (2 sync flops + edge)
        cal_exp[3] = 1;
        send_bits(cal_exp);
        ser_strobe = 1;
        wait_cyc(2);
        cal_done = 1;
        wait_cyc(1);
        cal_done = 0;
        wait_cyc(1);
        ser_strobe = 0;
        wait_cyc(8);
        chk("R9 commit wins over done", cal_start, 1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(2);
        t_reset();
        t_dev_write();
        t_no_strobe();
        t_bad_addr();
        t_gain();
        t_cal_done();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule